// File: doc/BRIEF.md
# Inbound Doorbell Queue Controller

This block takes doorbell events arriving from a serial link (an 8-bit source ID, an 8-bit target ID and a 16-bit info word) and stores each one as an 8-byte record in a circular queue held in memory. The queue is a 4 KB ring of 512 records. Two pointers track it: the enqueue pointer, which the hardware moves, and the dequeue pointer, which software moves. The upper pointer bits hold the ring base. The low 12 bits hold the offset within the ring, and that offset wraps.

Software loads both pointers with the ring base and then sets the enable bit. When the interrupt fires, software reads the record at the dequeue pointer. It then advances the dequeue pointer with a command bit in the mode register, and finally clears the doorbell-queued flag by writing a 1 to it. If the ring has no free slot, an incoming doorbell is dropped and the queue-full flag is raised. A doorbell flagged as errored by the link only raises the transfer-error flag.

Top module: `dbq_top`

## Requirements
- R1: After a synchronous reset, the mode, status, dequeue pointer and enqueue pointer registers all read 0, and `irq` and `mem_we` are low.
- R2: A doorbell that is accepted in cycle k produces a 64-bit write in cycle k+1. The record is big-endian, with byte 0 in bits 63:56. The target ID goes in byte 3 (bits 39:32), the source ID in byte 5 (bits 23:16) and the info word in bytes 6 and 7 (bits 15:0). All other bytes are zero.
- R3: The record is written at the current enqueue pointer. The pointer then advances by 8 in its low 12 bits, modulo 4096, and its upper bits stay unchanged.
- R4: The queue is full when the enqueue offset plus 8 (mod 4096) equals the dequeue offset, so at most 511 records can be outstanding. A doorbell that arrives while the queue is full is not written and does not move the enqueue pointer. It sets status bit 4 (0x10).
- R5: Every record that is written sets status bit 0 (0x01, doorbell queued).
- R6: A doorbell presented with `db_err` high sets status bit 7 (0x80). It writes nothing and does not move the enqueue pointer.
- R7: Writing the status register clears every flag whose write-data bit is 1. A flag that is set and cleared in the same cycle ends up set.
- R8: A mode write with bit 1 set advances the dequeue pointer by 8 within the ring, but only if the queue is not empty (the offsets differ); otherwise the command is ignored. Bit 1 is not stored and always reads 0. The other mode bits are stored as written.
- R9: While mode bit 0 (enable) is 0, doorbells are ignored: there is no write, no flag change and no pointer movement.
- R10: `irq` is high in cycle k+1 exactly when, in cycle k, any status flag is set and the unit is enabled.
- R11: `reg_rdata` in cycle k+1 shows the register selected by `reg_addr` in cycle k, as it stood in cycle k. The addresses are 0 for mode, 1 for status, 2 for the dequeue pointer and 3 for the enqueue pointer. A write to address 2 or 3 loads that pointer with the full write value, and this takes precedence over any advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| db_valid | input | 1 | Inbound doorbell present this cycle |
| db_err | input | 1 | Inbound doorbell carries a link error |
| db_src | input | 8 | Source ID |
| db_tgt | input | 8 | Target ID |
| db_info | input | 16 | Info word |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_we | output | 1 | Record write strobe |
| mem_addr | output | 32 | Byte address of the record |
| mem_wdata | output | 64 | Record contents |
| irq | output | 1 | Interrupt request |

## Verification
Each result has a fixed due time. The memory write, the new pointer values and the new flags all appear one clock after the doorbell or register write that causes them. `irq` follows a flag change one clock later, and read data appears one clock after its address. The bench drives every input on the falling edge. On the same falling edge it advances a behavioural model of queue state by one step. It then waits for the next rising edge and compares the outputs on the falling edge after it, so every comparison lands exactly on the cycle the requirements name. The directed checks add specific values on top of this: a ring filled to 511 records with its offset wrapping, an overflow, a set and a clear in the same cycle, an advance on an empty queue, and a unit that is disabled while a flag is still pending.

// File: rtl/dbq_pkg.sv
package dbq_pkg;
  typedef enum logic [1:0] {
    RA_MODE = 2'd0,
    RA_STAT = 2'd1,
    RA_DEQ  = 2'd2,
    RA_ENQ  = 2'd3
  } reg_addr_e;

  localparam int MD_EN     = 0;
  localparam int MD_ADV    = 1;
  localparam int ST_QUEUED = 0;
  localparam int ST_FULL   = 4;
  localparam int ST_ERR    = 7;

  // Big-endian 8-byte record: byte 3 target, byte 5 source, bytes 6..7 info.
  function automatic logic [63:0] pack_rec(input logic [7:0] tgt,
                                           input logic [7:0] src,
                                           input logic [15:0] info);
    return {24'h0, tgt, 8'h0, src, info};
  endfunction
endpackage

// File: rtl/dbq_ptr.sv
module dbq_ptr #(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  parameter int STEP  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] ptr_adv
);
  localparam logic [OFF_W-1:0] STEP_V = OFF_W'(STEP);

  assign ptr_adv = {ptr[AW-1:OFF_W], ptr[OFF_W-1:0] + STEP_V};

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (adv)  ptr <= ptr_adv;
  end

  // R3 / R8: an advance stays inside the ring and moves by one record
  a_r3_wrap_in_ring: assert property (@(posedge clk) disable iff (rst)
    (adv && !load) |=> (ptr[AW-1:OFF_W] == $past(ptr[AW-1:OFF_W])) &&
                       (ptr[OFF_W-1:0] == $past(ptr[OFF_W-1:0]) + STEP_V));
endmodule

// File: rtl/dbq_status.sv
module dbq_status #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] set_mask,
  input  logic [SW-1:0] clr_mask,
  input  logic          enable,
  output logic [SW-1:0] status,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~clr_mask) | set_mask;
      irq    <= (|status) && enable;
    end
  end

  // R7: a flag raised in a cycle survives a clear in that cycle
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|set_mask) |=> ((status & $past(set_mask)) == $past(set_mask)));

  // R10: the interrupt only follows a pending flag on an enabled unit
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past((|status) && enable));
endmodule

// File: rtl/dbq_fmt.sv
module dbq_fmt #(
  parameter int AW = 32,
  parameter int RW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    src,
  input  logic [7:0]    tgt,
  input  logic [15:0]   info,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [RW-1:0] mem_wdata
);
  import dbq_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= wr;
      if (wr) begin
        mem_addr  <= addr;
        mem_wdata <= RW'(pack_rec(tgt, src, info));
      end
    end
  end

  // R2: the reserved bytes of a written record are zero
  a_r2_layout: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata[63:40] == 24'h0) && (mem_wdata[31:24] == 8'h0));
endmodule

// File: rtl/dbq_top.sv
module dbq_top #(
  parameter int DW      = 32,
  parameter int ENTRIES = 512,
  parameter int REC_B   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          db_valid,
  input  logic          db_err,
  input  logic [7:0]    db_src,
  input  logic [7:0]    db_tgt,
  input  logic [15:0]   db_info,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  output logic          irq
);
  import dbq_pkg::*;

  localparam int OFF_W = $clog2(ENTRIES * REC_B);
  localparam int SW    = 8;

  logic [DW-1:0] mode_q;
  logic [DW-1:0] deq_ptr, deq_nxt, enq_ptr, enq_nxt;
  logic [SW-1:0] status, set_mask, clr_mask;
  logic en, q_full, q_empty, accept, wr_rec, deq_adv;
  logic wr_mode, wr_stat, wr_deq, wr_enq;

  assign en      = mode_q[MD_EN];
  assign wr_mode = reg_we && (reg_addr == RA_MODE);
  assign wr_stat = reg_we && (reg_addr == RA_STAT);
  assign wr_deq  = reg_we && (reg_addr == RA_DEQ);
  assign wr_enq  = reg_we && (reg_addr == RA_ENQ);

  assign q_full  = (enq_nxt[OFF_W-1:0] == deq_ptr[OFF_W-1:0]);
  assign q_empty = (enq_ptr[OFF_W-1:0] == deq_ptr[OFF_W-1:0]);
  assign accept  = db_valid && en && !db_err;
  assign wr_rec  = accept && !q_full;
  assign deq_adv = wr_mode && reg_wdata[MD_ADV] && !q_empty;

  always_comb begin
    set_mask            = '0;
    set_mask[ST_QUEUED] = wr_rec;
    set_mask[ST_FULL]   = accept && q_full;
    set_mask[ST_ERR]    = db_valid && en && db_err;
  end
  assign clr_mask = wr_stat ? reg_wdata[SW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (wr_mode) begin
      mode_q         <= reg_wdata;
      mode_q[MD_ADV] <= 1'b0;
    end
  end

  dbq_ptr #(.AW(DW), .OFF_W(OFF_W), .STEP(REC_B)) u_enq (
    .clk(clk), .rst(rst), .load(wr_enq), .load_val(reg_wdata),
    .adv(wr_rec), .ptr(enq_ptr), .ptr_adv(enq_nxt));

  dbq_ptr #(.AW(DW), .OFF_W(OFF_W), .STEP(REC_B)) u_deq (
    .clk(clk), .rst(rst), .load(wr_deq), .load_val(reg_wdata),
    .adv(deq_adv), .ptr(deq_ptr), .ptr_adv(deq_nxt));

  dbq_status #(.SW(SW)) u_stat (
    .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask),
    .enable(en), .status(status), .irq(irq));

  dbq_fmt #(.AW(DW), .RW(64)) u_fmt (
    .clk(clk), .rst(rst), .wr(wr_rec), .addr(enq_ptr),
    .src(db_src), .tgt(db_tgt), .info(db_info),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        RA_MODE: reg_rdata <= mode_q;
        RA_STAT: reg_rdata <= DW'(status);
        RA_DEQ:  reg_rdata <= deq_ptr;
        default: reg_rdata <= enq_ptr;
      endcase
    end
  end

  // R4: a doorbell on a full ring is dropped and leaves the enqueue pointer
  a_r4_full_drop: assert property (@(posedge clk) disable iff (rst)
    (accept && q_full && !wr_enq) |=> !mem_we && (enq_ptr == $past(enq_ptr)));

  // R9: a disabled unit writes nothing
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (db_valid && !en) |=> !mem_we);

  // R6: an errored doorbell writes nothing
  a_r6_err_nowrite: assert property (@(posedge clk) disable iff (rst)
    (db_valid && db_err) |=> !mem_we);

  // R8: the dequeue pointer never moves past the enqueue pointer on its own
  a_r8_no_adv_empty: assert property (@(posedge clk) disable iff (rst)
    (q_empty && !reg_we) |=> (deq_ptr == $past(deq_ptr)));
endmodule

// File: tb/sim_dbq_top.sv
module sim_dbq_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic db_valid = 1'b0, db_err = 1'b0;
  logic [7:0] db_src = '0, db_tgt = '0;
  logic [15:0] db_info = '0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_mode, m_deq, m_enq;
  logic [7:0]  m_stat;
  logic [31:0] rd;

  always #4 clk = ~clk;

  dbq_top u0 (
    .clk(clk), .rst(rst), .db_valid(db_valid), .db_err(db_err),
    .db_src(db_src), .db_tgt(db_tgt), .db_info(db_info),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq(irq));

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive inputs, step the model, compare after the edge
  task automatic step(input bit v, input bit e, input logic [7:0] s,
                      input logic [7:0] t, input logic [15:0] inf,
                      input bit we, input logic [1:0] a,
                      input logic [31:0] wd);
    logic [31:0] e_rd, e_addr, eo, no;
    logic [63:0] e_data;
    logic [7:0] set, clr;
    bit e_irq, full, acc, ew, adv, en;
    db_valid = v; db_err = e; db_src = s; db_tgt = t; db_info = inf;
    reg_we = we; reg_addr = a; reg_wdata = wd;

    case (a)
      2'd0: e_rd = m_mode;
      2'd1: e_rd = {24'h0, m_stat};
      2'd2: e_rd = m_deq;
      default: e_rd = m_enq;
    endcase
    en     = m_mode[0];
    e_irq  = (m_stat != 0) && en;
    eo     = m_enq & 32'hFFF;
    no     = (eo + 8) & 32'hFFF;
    full   = (no == (m_deq & 32'hFFF));
    acc    = v && en && !e;
    ew     = acc && !full;
    e_addr = m_enq;
    e_data = {24'h0, t, 8'h0, s, inf};
    set = 8'h0;
    if (v && en && e) set = set | 8'h80;
    if (acc && full)  set = set | 8'h10;
    if (ew)           set = set | 8'h01;
    clr = (we && a == 2'd1) ? wd[7:0] : 8'h0;
    adv = we && a == 2'd0 && wd[1] && ((m_enq & 32'hFFF) != (m_deq & 32'hFFF));

    m_stat = (m_stat & ~clr) | set;
    if (ew) m_enq = {m_enq[31:12], no[11:0]};
    if (we && a == 2'd3) m_enq = wd;
    if (adv) m_deq = {m_deq[31:12], (m_deq[11:0] + 12'd8)};
    if (we && a == 2'd2) m_deq = wd;
    if (we && a == 2'd0) m_mode = wd & ~32'h2;

    @(posedge clk);
    @(negedge clk);
    rd = reg_rdata;
    check(irq === e_irq, "R10 irq", 64'(irq), 64'(e_irq));
    check(mem_we === ew, "R2 write strobe", 64'(mem_we), 64'(ew));
    if (ew) begin
      check(mem_addr === e_addr, "R3 record address", 64'(mem_addr), 64'(e_addr));
      check(mem_wdata === e_data, "R2 record layout", mem_wdata, e_data);
    end
    check(reg_rdata === e_rd, "R11 read data", 64'(reg_rdata), 64'(e_rd));
  endtask

  task automatic idle(input logic [1:0] a);
    step(0, 0, 8'h0, 8'h0, 16'h0, 0, a, 32'h0);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    step(0, 0, 8'h0, 8'h0, 16'h0, 1, a, d);
  endtask

  task automatic bell(input bit e, input logic [7:0] s, input logic [7:0] t,
                      input logic [15:0] inf);
    step(1, e, s, t, inf, 0, 2'd0, 32'h0);
  endtask

  task automatic rreg(input logic [1:0] a);
    idle(a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_mode = 0; m_deq = 0; m_enq = 0; m_stat = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(irq === 1'b0 && mem_we === 1'b0, "R1 irq/mem_we after reset",
          64'({irq, mem_we}), 64'h0);
    for (int i = 0; i < 4; i++) begin
      rreg(2'(i));
      check(rd === 32'h0, "R1 register after reset", 64'(rd), 64'h0);
    end

    // ring base at 0x10000
    wreg(2'd2, 32'h0001_0000);
    wreg(2'd3, 32'h0001_0000);
    rreg(2'd3);
    check(rd === 32'h0001_0000, "R11 pointer load", 64'(rd), 64'h10000);

    // R9 disabled unit ignores doorbells
    bell(0, 8'h55, 8'h66, 16'h7777);
    rreg(2'd3);
    check(rd === 32'h0001_0000, "R9 enq unchanged while disabled", 64'(rd), 64'h10000);
    rreg(2'd1);
    check(rd === 32'h0, "R9 status unchanged while disabled", 64'(rd), 64'h0);

    // enable
    wreg(2'd0, 32'h0010_8161);
    rreg(2'd0);
    check(rd === 32'h0010_8161, "R8 mode readback", 64'(rd), 64'h108161);

    // R2 first record
    step(1, 0, 8'h12, 8'h34, 16'hBEEF, 0, 2'd1, 32'h0);
    check(mem_we === 1'b1 && mem_wdata === 64'h0000_0034_0012_BEEF,
          "R2 first record", mem_wdata, 64'h0000_0034_0012_BEEF);
    check(mem_addr === 32'h0001_0000, "R3 first record address",
          64'(mem_addr), 64'h10000);
    rreg(2'd1);
    check(rd === 32'h01, "R5 queued flag", 64'(rd), 64'h01);
    check(irq === 1'b1, "R10 irq raised", 64'(irq), 64'h1);

    // R8 advance, then clear
    wreg(2'd0, 32'h0010_8163);
    wreg(2'd1, 32'h0000_0001);
    rreg(2'd2);
    check(rd === 32'h0001_0008, "R8 dequeue advanced", 64'(rd), 64'h10008);
    rreg(2'd0);
    check(rd === 32'h0010_8161, "R8 command bit reads 0", 64'(rd), 64'h108161);
    rreg(2'd1);
    check(rd === 32'h0, "R7 queued flag cleared", 64'(rd), 64'h0);

    // R8 advance on empty ring ignored
    wreg(2'd0, 32'h0010_8163);
    rreg(2'd2);
    check(rd === 32'h0001_0008, "R8 empty advance ignored", 64'(rd), 64'h10008);

    // fill 511 records, wrapping the offset
    for (int i = 0; i < 511; i++)
      bell(0, 8'(i), 8'(i + 3), 16'(i * 7));
    rreg(2'd3);
    check(rd === 32'h0001_0000, "R3 enq wrapped in ring", 64'(rd), 64'h10000);

    // R4 overflow
    bell(0, 8'hAA, 8'hBB, 16'hCCCC);
    check(mem_we === 1'b0, "R4 full doorbell not written", 64'(mem_we), 64'h0);
    rreg(2'd3);
    check(rd === 32'h0001_0000, "R4 enq held when full", 64'(rd), 64'h10000);
    rreg(2'd1);
    check(rd === 32'h11, "R4 full flag", 64'(rd), 64'h11);

    // R6 errored doorbell
    bell(1, 8'h01, 8'h02, 16'h0003);
    rreg(2'd1);
    check(rd === 32'h91, "R6 error flag", 64'(rd), 64'h91);

    // R7 clear in the same cycle as a new full event
    step(1, 0, 8'h09, 8'h08, 16'h0007, 1, 2'd1, 32'h91);
    rreg(2'd1);
    check(rd === 32'h10, "R7 set wins over clear", 64'(rd), 64'h10);
    wreg(2'd1, 32'h10);
    idle(2'd1);
    idle(2'd1);
    check(irq === 1'b0, "R10 irq drops after clear", 64'(irq), 64'h0);

    // R10 disable with flag pending
    wreg(2'd0, 32'h0010_8163);
    bell(0, 8'h21, 8'h22, 16'h2323);
    wreg(2'd0, 32'h0);
    idle(2'd1);
    idle(2'd1);
    check(irq === 1'b0, "R10 irq low when disabled", 64'(irq), 64'h0);
    check(rd === 32'h01, "R10 flag still pending", 64'(rd), 64'h01);

    // R9 disabled again
    bell(0, 8'h31, 8'h32, 16'h3333);
    rreg(2'd3);
    check(rd === 32'h0001_0008, "R9 enq unchanged while disabled", 64'(rd), 64'h10008);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule